// File: doc/BRIEF.md
# Tracklet Coincidence Trigger

This block forms a fast trigger decision from the per-chip hit flags of a two-layer pixel tracker. Every frame delivers one bit per chip on the inner layer and one bit per chip on the outer layer. A bit is high when any pixel of that chip registered a hit. A programmable table lists chip pairs, each made of one inner chip and one outer chip, that lie on a straight line back to the collision region. A pair "fires" when both of its chips are hit.

The frame arrives with a mode bit that picks the algorithm. Any-pair mode reports, one clock after the frame, whether at least one enabled pair fired. Count mode reports, two clocks after the frame, how many enabled pairs fired. The count is summed by a pairwise adder tree. Software loads the pair table through a single-cycle register-write port. A table write that lands on the same edge as a frame never alters that frame's result.

The frame input has no back-pressure. A frame is accepted on every clock edge where `frm_valid` is high, including on consecutive edges. The result strobes are single-cycle pulses that cannot be stalled, so the consumer must take each result in the cycle it is presented.

Top module: `tkl_trigger`

## Requirements
- R1: Reset (`rst_n` low at a clock edge) disables every pair entry and clears all outputs to 0. A frame sent after reset, before any table write, gives hit 0 and count 0.
- R2: In any-pair mode (`frm_mode`=0), a frame accepted at edge k raises `or_valid` for one cycle after edge k. `or_hit` is 1 exactly when at least one enabled entry has both its inner chip and its outer chip hit.
- R3: In count mode (`frm_mode`=1), a frame accepted at edge k raises `cnt_valid` for one cycle after edge k+1. `cnt_value` equals the number of enabled entries with both chips hit, and never exceeds N_PAIRS.
- R4: The mode is taken per frame. A frame in any-pair mode produces no `cnt_valid` pulse, and a frame in count mode produces no `or_valid` pulse.
- R5: An entry whose enable bit is 0 never contributes. A table with every entry disabled yields `or_hit`=0 and `cnt_value`=0 for any input pattern.
- R6: An entry whose inner index is at least N_INNER, or whose outer index is at least N_OUTER, counts as not hit.
- R7: A write with `wr_en`=1 stores `wr_data` into entry `wr_addr`. The field layout is bit 13 enable, bits 12:7 inner index, bits 6:0 outer index. A frame accepted on the same edge as a write is evaluated with the table as it stood before the write. Later frames see the new entry.
- R8: While `or_valid` is 0, `or_hit` is 0. While `cnt_valid` is 0, `cnt_value` is 0.
- R9: Frames on consecutive edges are all accepted, and each produces its own result in order, with no stall.
- R10: Each entry counts on its own. Two entries holding the same chip pair both add to the count when that pair fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Pair table write strobe |
| wr_addr | input | 6 | Pair table entry to write |
| wr_data | input | 14 | Entry value {enable, inner index, outer index} |
| frm_valid | input | 1 | Frame present this cycle |
| frm_mode | input | 1 | 0 = any-pair result, 1 = pair count result |
| frm_inner | input | 40 | Inner-layer chip hit flags |
| frm_outer | input | 80 | Outer-layer chip hit flags |
| or_valid | output | 1 | Any-pair result strobe |
| or_hit | output | 1 | At least one enabled pair fired |
| cnt_valid | output | 1 | Count result strobe |
| cnt_value | output | 7 | Number of enabled pairs that fired |

## Verification
The any-pair result is due one clock after the frame edge, and the count result is due two clocks after it. The bench drives each frame on a falling edge. It samples the any-pair strobe and value on the next falling edge, and the count strobe and value on the falling edge after that. At each of these points it also confirms that the other mode's strobe stays low. For back-to-back frames and for a table write that coincides with a frame, the bench moves the sample point one falling edge per frame, so that each result is read in the cycle that frame's pipeline delivers it.

// File: rtl/tkl_pkg.sv
package tkl_pkg;
  localparam int IN_IDX_W  = 6;
  localparam int OUT_IDX_W = 7;

  typedef struct packed {
    logic                 en;
    logic [IN_IDX_W-1:0]  inner;
    logic [OUT_IDX_W-1:0] outer;
  } pair_t;

  localparam int PAIR_W = $bits(pair_t);
endpackage

// File: rtl/tkl_pair_map.sv
module tkl_pair_map
  import tkl_pkg::*;
#(
  parameter int N_PAIRS = 64,
  localparam int AW = $clog2(N_PAIRS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  pair_t               wr_entry,
  output pair_t [N_PAIRS-1:0] map_o
);
  pair_t [N_PAIRS-1:0] table_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_q <= '0;
    end else if (wr_en) begin
      table_q[wr_addr] <= wr_entry;
    end
  end

  assign map_o = table_q;
endmodule

// File: rtl/tkl_pair_eval.sv
module tkl_pair_eval
  import tkl_pkg::*;
#(
  parameter int N_INNER = 40,
  parameter int N_OUTER = 80,
  parameter int N_PAIRS = 64
) (
  input  logic [N_INNER-1:0] inner_i,
  input  logic [N_OUTER-1:0] outer_i,
  input  pair_t [N_PAIRS-1:0] map_i,
  output logic [N_PAIRS-1:0] hit_o
);
  localparam int IN_SPAN  = 1 << IN_IDX_W;
  localparam int OUT_SPAN = 1 << OUT_IDX_W;

  // Zero padding up to the full index range makes out-of-range indices read 0.
  logic [IN_SPAN-1:0]  in_pad;
  logic [OUT_SPAN-1:0] out_pad;

  assign in_pad  = IN_SPAN'(inner_i);
  assign out_pad = OUT_SPAN'(outer_i);

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign hit_o[p] = map_i[p].en & in_pad[map_i[p].inner] & out_pad[map_i[p].outer];
  end
endmodule

// File: rtl/tkl_popcount.sv
module tkl_popcount #(
  parameter int N_BITS = 64,
  parameter int CW     = $clog2(N_BITS + 1)
) (
  input  logic [N_BITS-1:0] bits_i,
  output logic [CW-1:0]     sum_o
);
  localparam int LV  = $clog2(N_BITS);
  localparam int NPW = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    logic [CW-1:0] s [NPW >> l];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < NPW; i++) begin : g_in
        if (i < N_BITS) begin : g_real
          assign s[i] = CW'(bits_i[i]);
        end else begin : g_pad
          assign s[i] = '0;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < (NPW >> l); i++) begin : g_add
        assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
      end
    end
  end

  assign sum_o = g_lvl[LV].s[0];
endmodule

// File: rtl/tkl_trigger.sv
module tkl_trigger
  import tkl_pkg::*;
#(
  parameter int N_INNER = 40,
  parameter int N_OUTER = 80,
  parameter int N_PAIRS = 64,
  localparam int AW = $clog2(N_PAIRS),
  localparam int CW = $clog2(N_PAIRS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [PAIR_W-1:0]  wr_data,
  input  logic               frm_valid,
  input  logic               frm_mode,
  input  logic [N_INNER-1:0] frm_inner,
  input  logic [N_OUTER-1:0] frm_outer,
  output logic               or_valid,
  output logic               or_hit,
  output logic               cnt_valid,
  output logic [CW-1:0]      cnt_value
);
  pair_t [N_PAIRS-1:0] map;
  logic  [N_PAIRS-1:0] hit;
  logic  [N_PAIRS-1:0] hit_q;
  logic                cnt_pend;
  logic  [CW-1:0]      tree_sum;

  tkl_pair_map #(.N_PAIRS(N_PAIRS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_entry (pair_t'(wr_data)),
    .map_o    (map)
  );

  tkl_pair_eval #(.N_INNER(N_INNER), .N_OUTER(N_OUTER), .N_PAIRS(N_PAIRS)) u_eval (
    .inner_i (frm_inner),
    .outer_i (frm_outer),
    .map_i   (map),
    .hit_o   (hit)
  );

  tkl_popcount #(.N_BITS(N_PAIRS), .CW(CW)) u_tree (
    .bits_i (hit_q),
    .sum_o  (tree_sum)
  );

  // Stage 1: any-pair result and captured pair hits for the count path.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      or_valid <= 1'b0;
      or_hit   <= 1'b0;
      cnt_pend <= 1'b0;
      hit_q    <= '0;
    end else begin
      or_valid <= frm_valid & ~frm_mode;
      or_hit   <= frm_valid & ~frm_mode & (|hit);
      cnt_pend <= frm_valid & frm_mode;
      hit_q    <= (frm_valid & frm_mode) ? hit : '0;
    end
  end

  // Stage 2: registered adder tree sum.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_valid <= 1'b0;
      cnt_value <= '0;
    end else begin
      cnt_valid <= cnt_pend;
      cnt_value <= cnt_pend ? tree_sum : '0;
    end
  end
endmodule

// File: rtl/tkl_trigger_chk.sv
module tkl_trigger_chk #(
  parameter int N_PAIRS = 64,
  parameter int CW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_valid,
  input logic          frm_mode,
  input logic          or_valid,
  input logic          or_hit,
  input logic          cnt_valid,
  input logic [CW-1:0] cnt_value
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  p_or_latency_r2: assert property (@(posedge clk) disable iff (!rst_n || cyc == 2'd0)
    or_valid == $past(frm_valid && !frm_mode));

  p_cnt_latency_r3: assert property (@(posedge clk) disable iff (!rst_n || cyc != 2'd2)
    cnt_valid == $past(frm_valid && frm_mode, 2));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> int'(cnt_value) <= N_PAIRS);

  p_mode_excl_r4: assert property (@(posedge clk) disable iff (!rst_n || cyc == 2'd0)
    $past(frm_valid && frm_mode) |-> !or_valid);

  p_or_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !or_valid |-> !or_hit);

  p_cnt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_valid |-> cnt_value == '0);
endmodule

bind tkl_trigger tkl_trigger_chk #(.N_PAIRS(N_PAIRS), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_mode  (frm_mode),
  .or_valid  (or_valid),
  .or_hit    (or_hit),
  .cnt_valid (cnt_valid),
  .cnt_value (cnt_value)
);

// File: tb/tkl_trigger_tb.sv
module tkl_trigger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [13:0] wr_data = '0;
  logic        frm_valid = 1'b0;
  logic        frm_mode = 1'b0;
  logic [39:0] frm_inner = '0;
  logic [79:0] frm_outer = '0;
  logic        or_valid, or_hit, cnt_valid;
  logic [6:0]  cnt_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tkl_trigger u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frm_valid(frm_valid), .frm_mode(frm_mode), .frm_inner(frm_inner), .frm_outer(frm_outer),
    .or_valid(or_valid), .or_hit(or_hit), .cnt_valid(cnt_valid), .cnt_value(cnt_value)
  );

  // {inner 40, outer 80, expected count 7}
  localparam logic [126:0] VEC [8] = '{
    {40'h0,             80'h0,                         7'd0},
    {40'h8,             80'h20,                        7'd1},
    {40'h8,             80'h60,                        7'd2},
    {40'h400,           80'h10_0000,                   7'd2},
    {40'h1,             80'h1,                         7'd0},
    {40'hFF_FFFF_FFFF,  80'hFFFF_FFFF_FFFF_FFFF_FFFF,  7'd5},
    {40'h80_0000_0000,  80'h8000_0000_0000_0000_0000,  7'd1},
    {40'h8,             80'h10_0000,                   7'd0}
  };

  function automatic string vec_tag(int v);
    case (v)
      3: return "R10";
      4: return "R5";
      5: return "R6";
      default: return "R2/R3";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, bit en, int inner, int outer);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(addr); wr_data = {en, 6'(inner), 7'(outer)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_frame(bit mode, logic [39:0] fi, logic [79:0] fo, int exp_cnt, string tag);
    @(negedge clk);
    frm_valid = 1'b1; frm_mode = mode; frm_inner = fi; frm_outer = fo;
    @(negedge clk);
    frm_valid = 1'b0;
    chk({tag, " R2 or_valid"}, int'(or_valid), mode ? 0 : 1);
    chk({tag, " R2 or_hit"}, int'(or_hit), (!mode && exp_cnt != 0) ? 1 : 0);
    @(negedge clk);
    chk({tag, " R4 cnt_valid"}, int'(cnt_valid), mode ? 1 : 0);
    chk({tag, " R3 cnt_value"}, int'(cnt_value), mode ? exp_cnt : 0);
    chk({tag, " R4/R8 or quiet"}, int'(or_valid) + int'(or_hit), 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R1 or_valid", int'(or_valid), 0);
    chk("R1 or_hit", int'(or_hit), 0);
    chk("R1 cnt_valid", int'(cnt_valid), 0);
    chk("R1 cnt_value", int'(cnt_value), 0);
    run_frame(1'b1, '1, '1, 0, "R1 empty table");
    run_frame(1'b0, '1, '1, 0, "R1/R5 empty table");

    wr(0, 1, 3, 5);
    wr(1, 1, 3, 6);
    wr(2, 1, 10, 20);
    wr(3, 1, 39, 79);
    wr(4, 1, 10, 20);
    wr(5, 0, 0, 0);
    wr(6, 1, 45, 0);
    wr(7, 1, 0, 90);

    for (int v = 0; v < 8; v++) begin
      for (int m = 0; m < 2; m++) begin
        run_frame(m[0], VEC[v][126:87], VEC[v][86:7], int'(VEC[v][6:0]), vec_tag(v));
      end
    end

    // R9: back-to-back count frames.
    @(negedge clk);
    frm_valid = 1'b1; frm_mode = 1'b1; frm_inner = 40'h8; frm_outer = 80'h60;
    @(negedge clk);
    frm_inner = 40'hFF_FFFF_FFFF; frm_outer = '1;
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R9 first cnt_valid", int'(cnt_valid), 1);
    chk("R9 first cnt_value", int'(cnt_value), 2);
    @(negedge clk);
    chk("R9 second cnt_valid", int'(cnt_valid), 1);
    chk("R9 second cnt_value", int'(cnt_value), 5);
    @(negedge clk);
    chk("R9 tail quiet", int'(cnt_valid), 0);

    // R7: write disabling entry 0 on the same edge as a frame.
    @(negedge clk);
    frm_valid = 1'b1; frm_mode = 1'b0; frm_inner = 40'h8; frm_outer = 80'h20;
    wr_en = 1'b1; wr_addr = 6'd0; wr_data = {1'b0, 6'd3, 7'd5};
    @(negedge clk);
    frm_valid = 1'b0; wr_en = 1'b0;
    chk("R7 same-edge frame uses old table", int'(or_hit), 1);
    run_frame(1'b0, 40'h8, 80'h20, 0, "R7 later frame sees write");
    run_frame(1'b1, 40'h8, 80'h60, 1, "R7 count after write");

    // R1: reset clears the table.
    do_reset();
    chk("R1 cnt_value after reset", int'(cnt_value), 0);
    run_frame(1'b1, '1, '1, 0, "R1 table cleared");
    run_frame(1'b0, 40'h400, 80'h10_0000, 0, "R1/R5 table cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule